// File: doc/BRIEF.md
# Conversion-Synchronized Channel Sequencer

This block walks an analog multiplexer through four inputs of a data-acquisition front end: the three accelerometer axes and a fixed reference voltage. The reference is sampled so that later stages can correct the axis readings ratiometrically. The sequencer advances only when the converter signals that a conversion has finished. There is no processor in the loop, so the select lines change at a fixed point after every conversion and no software latency is involved.

Each finished 12-bit result is filed into the holding register of the channel that was selected while that conversion ran. The select then moves to the next channel on the same clock edge. A per-channel valid flag marks fresh data, and a one-cycle strobe marks the end of a complete set of channels.

Because one converter serves four inputs, the converter must run at the per-channel rate times four. For example, 60 kSPS per axis means 180 kSPS for the three axes, and 240 kSPS once the reference channel is included.

Top module: `conv_sync_sequencer`

## Requirements
- R1: After reset (active-low `rst_n`), `mux_sel` is 0, all channel registers read 0, every valid flag is 0 and `frame_done` is 0.
- R2: Only a rising edge of `eoc`, sampled in the system clock domain, is a conversion event. An `eoc` level held high for several cycles counts as one event.
- R3: On each event taken while `enable` is high, `mux_sel` steps through the fixed order 0=X, 1=Y, 2=Z, 3=reference and then wraps from 3 to 0. `mux_sel` changes at no other time.
- R4: On an event, the value on `result` is stored in the channel register given by `mux_sel` before the advance. Channel k occupies bits [12k+11:12k] of `ch_data`.
- R5: On an event, the valid flag of the captured channel (bit k of `ch_valid`) is set on the same edge.
- R6: A high `rd_ack[k]` clears `ch_valid[k]` on the next edge. If a capture into channel k happens on that same edge, the capture wins and the flag stays set.
- R7: A capture into channel X starts a new frame and clears the valid flags of channels Y, Z and reference.
- R8: `frame_done` is high for exactly one cycle, in the cycle after the reference channel (3) is captured, and is low at all other times.
- R9: While `enable` is low, `mux_sel` is held and no register or flag is written by `eoc`. A rising edge that occurs while `enable` is low is not replayed when `enable` returns high.
- R10: A capture changes only the register of the captured channel. The other channel registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Sequencing enable. When low, the select is held and events are dropped |
| eoc | input | 1 | Converter end-of-conversion, rising-edge significant |
| result | input | 12 | Converter result, valid while `eoc` is high |
| rd_ack | input | 4 | Per-channel read acknowledge that clears the valid flag |
| mux_sel | output | 2 | Multiplexer select (0=X, 1=Y, 2=Z, 3=reference) |
| ch_data | output | 48 | Four 12-bit channel registers, channel k at bits [12k+11:12k] |
| ch_valid | output | 4 | Per-channel fresh-data flags |
| frame_done | output | 1 | One-cycle strobe after the reference channel is captured |

## Verification
The assertions watch the sequencing rules on every cycle:
- the select moves only after an enabled rising edge of `eoc`;
- the select always moves by one step with the wrap;
- the result lands in the register of the previous select and that channel's flag is set;
- the strobe is a single cycle that follows a capture of the reference channel;
- the select is held while `enable` is low.

The flag interplay is shown only by the bench scenarios run against its reference model. These cover the acknowledge-versus-capture collision, the clearing of stale flags at the start of a frame, untouched neighbour registers, long `eoc` levels and edges lost while the block is disabled.

// File: rtl/conv_sync_sequencer_pkg.sv
// Package: shared sizes and channel codes for the conversion-synchronized
// sequencer. Assumes a power-of-two channel count is not required; the
// counter wraps explicitly at the last channel.
package conv_sync_sequencer_pkg;

    localparam int unsigned SEQ_N_CH   = 4;
    localparam int unsigned SEQ_DATA_W = 12;

    // Channel codes in sequence order; the reference is always the last one.
    typedef enum logic [1:0] {
        CH_AXIS_X = 2'd0,
        CH_AXIS_Y = 2'd1,
        CH_AXIS_Z = 2'd2,
        CH_REF    = 2'd3
    } chan_code_t;

endpackage

// File: rtl/seq_eoc_edge.sv
// Module: seq_eoc_edge
// Turns the converter end-of-conversion level into a single-cycle event on
// its rising edge. Assumes eoc is already synchronous to clk (the converter
// runs from the same clock tree). A long high level yields one event.
module seq_eoc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc,
    output logic eoc_rise
);

    logic eoc_q;

    // Hold last sampled eoc level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q <= 1'b0;
        end else begin
            eoc_q <= eoc;
        end
    end

    // Event is the current high level against a low previous level.
    always_comb begin
        eoc_rise = eoc && !eoc_q;
    end

endmodule

// File: rtl/seq_chan_counter.sv
// Module: seq_chan_counter
// Holds the multiplexer select and steps it on each accepted event, wrapping
// from the last channel to channel 0. Also produces the end-of-frame strobe
// one cycle after the last channel is captured. Assumes 'advance' is
// already qualified with enable.
module seq_chan_counter #(
    parameter int unsigned N_CH = 4,
    localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [SEL_W-1:0] sel,
    output logic             frame_done
);

    localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(N_CH - 1);

    logic at_last;

    // Flag the final channel of the sequence.
    always_comb begin
        at_last = (sel == LAST_CH);
    end

    // Step the select on accepted events, wrapping after the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (advance) begin
            sel <= at_last ? '0 : sel + 1'b1;
        end
    end

    // Pulse the frame strobe for one cycle after the last channel is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
        end else begin
            frame_done <= advance && at_last;
        end
    end

endmodule

// File: rtl/seq_capture_bank.sv
// Module: seq_capture_bank
// One holding register and one valid flag per channel. A capture writes only
// the selected channel. A capture into channel 0 opens a new frame and
// clears the other flags. A read acknowledge clears a flag unless a capture
// into that channel happens on the same edge.
module seq_capture_bank #(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]        result,
    input  logic [N_CH-1:0]          rd_ack,
    output logic [N_CH*DATA_W-1:0]   ch_data,
    output logic [N_CH-1:0]          ch_valid
);

    logic new_frame;

    // A capture into the first channel marks the start of a new frame.
    always_comb begin
        new_frame = capture && (sel == '0);
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_chan
        logic hit;
        logic drop;

        // Decode whether this channel is written or invalidated this cycle.
        always_comb begin
            hit  = capture && (sel == SEL_W'(k));
            drop = rd_ack[k] || (new_frame && (k != 0));
        end

        // Store the result for this channel when it is the captured one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_data[k*DATA_W +: DATA_W] <= '0;
            end else if (hit) begin
                ch_data[k*DATA_W +: DATA_W] <= result;
            end
        end

        // Maintain the fresh-data flag; a capture outranks any clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_valid[k] <= 1'b0;
            end else if (hit) begin
                ch_valid[k] <= 1'b1;
            end else if (drop) begin
                ch_valid[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/conv_sync_sequencer.sv
// Module: conv_sync_sequencer (top)
// Steps the multiplexer select through X, Y, Z and reference on converter
// end-of-conversion rising edges and files each result under the channel
// that was selected while it converted. Assumes the result is stable while
// eoc is high and that eoc shares the system clock.
module conv_sync_sequencer #(
    parameter int unsigned N_CH   = conv_sync_sequencer_pkg::SEQ_N_CH,
    parameter int unsigned DATA_W = conv_sync_sequencer_pkg::SEQ_DATA_W,
    localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   eoc,
    input  logic [DATA_W-1:0]      result,
    input  logic [N_CH-1:0]        rd_ack,
    output logic [SEL_W-1:0]       mux_sel,
    output logic [N_CH*DATA_W-1:0] ch_data,
    output logic [N_CH-1:0]        ch_valid,
    output logic                   frame_done
);

    logic eoc_rise;
    logic take;

    seq_eoc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoc      (eoc),
        .eoc_rise (eoc_rise)
    );

    // Accept an event only while sequencing is enabled.
    always_comb begin
        take = eoc_rise && enable;
    end

    seq_chan_counter #(
        .N_CH (N_CH)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (take),
        .sel        (mux_sel),
        .frame_done (frame_done)
    );

    seq_capture_bank #(
        .N_CH   (N_CH),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take),
        .sel      (mux_sel),
        .result   (result),
        .rd_ack   (rd_ack),
        .ch_data  (ch_data),
        .ch_valid (ch_valid)
    );

endmodule

// File: rtl/conv_sync_sequencer_chk.sv
// Module: conv_sync_sequencer_chk
// Property checker bound to the sequencer top. Observes ports only and keeps
// its own one-cycle history of eoc, select and result.
module conv_sync_sequencer_chk #(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable,
    input logic                   eoc,
    input logic [DATA_W-1:0]      result,
    input logic [SEL_W-1:0]       mux_sel,
    input logic [N_CH*DATA_W-1:0] ch_data,
    input logic [N_CH-1:0]        ch_valid,
    input logic                   frame_done
);

    localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(N_CH - 1);

    logic              eoc_d;
    logic              ev_d;
    logic [SEL_W-1:0]  sel_d;
    logic [DATA_W-1:0] res_d;

    // Record last-cycle inputs and select for the properties below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_d <= 1'b0;
            ev_d  <= 1'b0;
            sel_d <= '0;
            res_d <= '0;
        end else begin
            eoc_d <= eoc;
            ev_d  <= eoc && !eoc_d && enable;
            sel_d <= mux_sel;
            res_d <= result;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mux_sel == '0) && (ch_valid == '0) && !frame_done);

    assert_moves_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != sel_d) |-> ev_d);

    assert_event_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_d |-> (mux_sel != sel_d) || (N_CH == 1));

    assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_d |-> mux_sel == ((sel_d == LAST_CH) ? '0 : SEL_W'(sel_d + 1'b1)));

    assert_data_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_d |-> ch_data[sel_d*DATA_W +: DATA_W] == res_d);

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_d |-> ch_valid[sel_d]);

    assert_frame_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ev_d && (sel_d == LAST_CH));

    assert_frame_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(mux_sel) && !frame_done);

endmodule

bind conv_sync_sequencer conv_sync_sequencer_chk #(
    .N_CH   (N_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .eoc        (eoc),
    .result     (result),
    .mux_sel    (mux_sel),
    .ch_data    (ch_data),
    .ch_valid   (ch_valid),
    .frame_done (frame_done)
);

// File: tb/conv_sync_sequencer_test.sv
module conv_sync_sequencer_test;

    localparam int NCH = 4;
    localparam int DW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            eoc = 1'b0;
    logic [DW-1:0]   result = '0;
    logic [NCH-1:0]  rd_ack = '0;
    logic [1:0]      mux_sel;
    logic [NCH*DW-1:0] ch_data;
    logic [NCH-1:0]  ch_valid;
    logic            frame_done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    logic [1:0]      m_sel;
    logic [DW-1:0]   m_data [NCH];
    logic [NCH-1:0]  m_valid;
    logic            m_frame;
    logic            m_eoc_prev;

    always #10 clk = ~clk;

    conv_sync_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .eoc(eoc), .result(result),
        .rd_ack(rd_ack), .mux_sel(mux_sel), .ch_data(ch_data),
        .ch_valid(ch_valid), .frame_done(frame_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] model_data();
        logic [NCH*DW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*DW +: DW] = m_data[k];
        return v;
    endfunction

    task automatic model_reset();
        m_sel = 0; m_valid = 0; m_frame = 0; m_eoc_prev = 0;
        for (int k = 0; k < NCH; k++) m_data[k] = '0;
    endtask

    // Next state from the requirements: R2 edge, R3 order, R4/R10 data,
    // R5/R6/R7 flags, R8 strobe, R9 enable.
    task automatic model_step(input logic e, input logic en,
                              input logic [NCH-1:0] ak, input logic [DW-1:0] res);
        logic take;
        logic [NCH-1:0] nv;
        take = e && !m_eoc_prev && en;
        m_eoc_prev = e;
        nv = m_valid & ~ak;
        m_frame = take && (m_sel == 2'd3);
        if (take) begin
            m_data[m_sel] = res;
            if (m_sel == 2'd0) nv[NCH-1:1] = '0;
            nv[m_sel] = 1'b1;
            m_sel = m_sel + 2'd1;
        end
        m_valid = nv;
    endtask

    task automatic compare_all();
        chk("R3 mux_sel", 64'(mux_sel), 64'(m_sel));
        chk("R4 R10 ch_data", 64'(ch_data), 64'(model_data()));
        chk("R5/R6/R7 ch_valid", 64'(ch_valid), 64'(m_valid));
        chk("R8 frame_done", 64'(frame_done), 64'(m_frame));
    endtask

    // Drive one cycle at the falling edge, clock it, then compare.
    task automatic step(input logic e, input logic en,
                        input logic [NCH-1:0] ak, input logic [DW-1:0] res);
        eoc = e; enable = en; rd_ack = ak; result = res;
        model_step(e, en, ak, res);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] s0;
        logic [DW-1:0] d0;
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mux_sel", 64'(mux_sel), 0);
        chk("R1 ch_data", 64'(ch_data), 0);
        chk("R1 ch_valid", 64'(ch_valid), 0);
        chk("R1 frame_done", 64'(frame_done), 0);
        rst_n = 1'b1;

        // R3 R4 R8: one full frame with known values
        for (int k = 0; k < NCH; k++) begin
            step(1'b1, 1'b1, '0, DW'(12'h111 * (k + 1)));
            if (k == NCH - 1) chk("R8 strobe after ref", 64'(frame_done), 1);
            else chk("R8 no strobe mid frame", 64'(frame_done), 0);
            step(1'b0, 1'b1, '0, '0);
        end
        chk("R3 wrapped to X", 64'(mux_sel), 0);
        chk("R4 ref register", 64'(ch_data[3*DW +: DW]), 64'h444);

        // R2: long eoc level counts once
        s0 = mux_sel;
        step(1'b1, 1'b1, '0, 12'hABC);
        repeat (5) step(1'b1, 1'b1, '0, 12'h555);
        chk("R2 one step for long level", 64'(mux_sel), 64'(2'(s0 + 1)));
        step(1'b0, 1'b1, '0, '0);

        // R9: edges while disabled are dropped and not replayed
        s0 = mux_sel;
        d0 = ch_data[s0*DW +: DW];
        step(1'b1, 1'b0, '0, 12'hFFF);
        step(1'b1, 1'b1, '0, 12'hFFF);
        chk("R9 select held", 64'(mux_sel), 64'(s0));
        chk("R9 register untouched", 64'(ch_data[s0*DW +: DW]), 64'(d0));
        step(1'b0, 1'b1, '0, '0);

        // R6: ack clears, capture outranks ack on same channel
        step(1'b0, 1'b1, 4'b0001, '0);
        chk("R6 ack clears X flag", 64'(ch_valid[0]), 0);
        s0 = mux_sel;
        step(1'b1, 1'b1, 4'(1 << s0), 12'h321);
        chk("R6 capture wins over ack", 64'(ch_valid[s0]), 1);
        step(1'b0, 1'b1, '0, '0);

        // R7: advance to X and capture; other flags cleared
        while (mux_sel != 2'd0) begin
            step(1'b1, 1'b1, '0, 12'h0F0);
            step(1'b0, 1'b1, '0, '0);
        end
        chk("R7 flags before new frame", 64'(ch_valid[3]), 1);
        step(1'b1, 1'b1, '0, 12'h777);
        chk("R7 new frame flags", 64'(ch_valid), 64'b0001);
        step(1'b0, 1'b1, '0, '0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic e;
            logic en;
            e  = ($urandom % 3) == 0;
            en = ($urandom % 8) != 0;
            step(e, en, NCH'(($urandom % 4) == 0 ? $urandom : 0), DW'($urandom));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule